// File: doc/BRIEF.md
# Delay-Modulated Dataflow Actor

This block evaluates one elementary dataflow operation each time it is fired. A firing presents up to two 32-bit operands, a coefficient and a function code. The block forms one 32-bit result in signed Q16.16 fixed point and pushes it into the actor's own delay line. What the block emits is taken from that line, so a firing's result can surface again several firings later. A small control word picks the distance back into the line. It is sampled on every firing, so the delay can sweep over time and produce effects such as flanging or a moving tap.

The longest delay is a build parameter. It may be zero, in which case the block is a plain registered function unit. Each output is registered and appears one clock after its fire strobe. At most one firing is accepted per clock.

Top module: `dataflow_actor_delay`

## Requirements
- R1: Function code 0 (constant) makes the firing's result equal to `coef`, whatever `x1` and `x2` hold.
- R2: Function code 2 (sum) gives `x1 + x2` in 32-bit two's complement, wrapping on overflow.
- R3: Function code 3 (product) gives the signed product of `x1` and `x2` shifted right arithmetically by 16 bits. It saturates to 0x7FFFFFFF or 0x80000000 when it leaves the 32-bit signed range.
- R4: Function code 4 (scale) gives the saturated Q16.16 product of `coef` and `x1`. Function code 1 (multiply-add) gives that same saturated product plus `x2`, wrapping. Codes 5, 6 and 7 give zero.
- R5: The effective delay of a firing is floor(MAX_DELAY × `dly_ctrl` / 2^CTRL_W), capped at MAX_DELAY. `dly_ctrl` is read as an unsigned fraction.
- R6: With an effective delay of zero, the output after a firing is that firing's own result.
- R7: With an effective delay d > 0, the output after a firing is the result of the firing d firings earlier. It is zero if fewer than d firings have happened since reset.
- R8: `y_valid` is high in exactly the cycle after a firing. When no firing occurs, `y` keeps its value.
- R9: During reset `y` and `y_valid` are zero, and all firing history is forgotten.
- R10: Only firings advance the delay line, so idle cycles between firings do not shift which earlier result is reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fire | input | 1 | Fire strobe, one firing per high cycle |
| fn_sel | input | 3 | Function code (see R1–R4) |
| coef | input | 32 | Coefficient, Q16.16 |
| x1 | input | 32 | First operand, Q16.16 |
| x2 | input | 32 | Second operand, Q16.16 |
| dly_ctrl | input | CTRL_W | Delay control fraction |
| y | output | 32 | Delayed result |
| y_valid | output | 1 | High the cycle after a firing |

## Verification
Within a single firing the line is written with the new result and read from an older slot. The read takes one of three paths: the same-edge bypass at delay zero, a slot written earlier, or the zero substitute for a slot that has never been written since reset. The bench provokes all three back to back. It sweeps the control word through every value right after reset and again after a mid-run reset, so that the effective delay passes, firing by firing, through the values that equal, exceed and trail the count of firings so far. Each output is judged against a bench model that keeps its own history of computed results and counts only firings.

// File: rtl/actor_pkg.sv
// Shared function codes for the dataflow actor.
// Assumes a 3-bit function selector; unlisted codes produce zero.
package actor_pkg;
    typedef enum logic [2:0] {
        FN_CONST = 3'd0,
        FN_MAD   = 3'd1,
        FN_ADD   = 3'd2,
        FN_MUL   = 3'd3,
        FN_AMP   = 3'd4
    } actor_fn_e;
endpackage

// File: rtl/actor_alu.sv
// Combinational function unit of the actor: evaluates the selected
// operation on Q16.16 operands. Products are saturated, sums wrap.
// Assumes FRAC_W < DATA_W.
module actor_alu #(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 16
) (
    input  logic [2:0]        fn_sel,
    input  logic [DATA_W-1:0] coef,
    input  logic [DATA_W-1:0] x1,
    input  logic [DATA_W-1:0] x2,
    output logic [DATA_W-1:0] res
);
    import actor_pkg::*;

    localparam int PW = 2 * DATA_W;

    // Saturating fixed-point product of two signed operands.
    function automatic logic [DATA_W-1:0] mul_sat(input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
        logic signed [PW-1:0] full;
        logic signed [PW-1:0] sh;
        full = $signed(a) * $signed(b);
        sh   = full >>> FRAC_W;
        if (sh[PW-1:DATA_W-1] == '0 || sh[PW-1:DATA_W-1] == '1)
            return sh[DATA_W-1:0];
        else if (sh[PW-1])
            return {1'b1, {(DATA_W-1){1'b0}}};
        else
            return {1'b0, {(DATA_W-1){1'b1}}};
    endfunction

    logic [DATA_W-1:0] px1;

    // Coefficient-by-operand product, shared by scale and multiply-add.
    always_comb px1 = mul_sat(coef, x1);

    // Select the function result.
    always_comb begin
        case (fn_sel)
            FN_CONST: res = coef;
            FN_MAD:   res = px1 + x2;
            FN_ADD:   res = x1 + x2;
            FN_MUL:   res = mul_sat(x1, x2);
            FN_AMP:   res = px1;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/delay_tap.sv
// Converts the delay control fraction into an effective delay in
// firings: floor(MAX_DELAY * ctrl / 2^CTRL_W), capped at MAX_DELAY.
// Assumes DLY_W holds MAX_DELAY.
module delay_tap #(
    parameter int MAX_DELAY = 12,
    parameter int CTRL_W    = 8,
    parameter int DLY_W     = 4
) (
    input  logic [CTRL_W-1:0] ctrl,
    output logic [DLY_W-1:0]  eff
);
    localparam int PRW = DLY_W + CTRL_W;

    logic [PRW-1:0] prod;
    logic [PRW-1:0] scaled;

    // Scale the fraction by the configured maximum.
    always_comb begin
        prod   = PRW'(MAX_DELAY) * PRW'(ctrl);
        scaled = prod >> CTRL_W;
    end

    // Cap the result at the configured maximum.
    always_comb begin
        if (scaled > PRW'(MAX_DELAY))
            eff = DLY_W'(MAX_DELAY);
        else
            eff = scaled[DLY_W-1:0];
    end
endmodule

// File: rtl/actor_delay_line.sv
// Per-actor circular delay line. Each firing writes its result at the
// write pointer and reads the slot `eff` firings back. A delay of zero
// bypasses the memory. Slots not yet written since reset read as zero;
// a fill counter tracks this, so the memory itself needs no reset.
// Assumes eff <= MAX_DELAY < 2^DLY_W.
module actor_delay_line #(
    parameter int DATA_W    = 32,
    parameter int MAX_DELAY = 12,
    parameter int DLY_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] din,
    input  logic [DLY_W-1:0]  eff,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);
    localparam int DEPTH = 1 << DLY_W;
    localparam int FCW   = DLY_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DLY_W-1:0]  wptr;
    logic [FCW-1:0]    fill;
    logic [DLY_W-1:0]  rd_addr;

    // Read address trails the write pointer by the effective delay.
    always_comb rd_addr = wptr - eff;

    // Memory write port, one slot per firing.
    always_ff @(posedge clk) begin
        if (fire)
            mem[wptr] <= din;
    end

    // Pointer, fill count and registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            fill   <= '0;
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= fire;
            if (fire) begin
                wptr <= wptr + 1'b1;
                if (fill != FCW'(DEPTH))
                    fill <= fill + 1'b1;
                if (eff == '0)
                    dout <= din;
                else if ({1'b0, eff} > fill)
                    dout <= '0;
                else
                    dout <= mem[rd_addr];
            end
        end
    end

    assert_eff_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (eff <= DLY_W'(MAX_DELAY)));

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FCW'(DEPTH));

    assert_valid_after_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> dvalid);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(dout));
endmodule

// File: rtl/dataflow_actor_delay.sv
// Top of the dataflow actor: function unit, delay tap and delay line.
// Each fire strobe evaluates one function on Q16.16 operands and pushes
// the result into the delay line. The output, valid one clock later, is
// the result from the effective delay's worth of firings back.
// Assumes at most one firing per clock.
module dataflow_actor_delay #(
    parameter int DATA_W    = 32,
    parameter int FRAC_W    = 16,
    parameter int MAX_DELAY = 12,
    parameter int CTRL_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [2:0]        fn_sel,
    input  logic [DATA_W-1:0] coef,
    input  logic [DATA_W-1:0] x1,
    input  logic [DATA_W-1:0] x2,
    input  logic [CTRL_W-1:0] dly_ctrl,
    output logic [DATA_W-1:0] y,
    output logic              y_valid
);
    localparam int DLY_W = (MAX_DELAY < 1) ? 1 : $clog2(MAX_DELAY + 1);

    logic [DATA_W-1:0] res;
    logic [DLY_W-1:0]  eff;

    actor_alu #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) i_alu (
        .fn_sel (fn_sel),
        .coef   (coef),
        .x1     (x1),
        .x2     (x2),
        .res    (res)
    );

    delay_tap #(.MAX_DELAY(MAX_DELAY), .CTRL_W(CTRL_W), .DLY_W(DLY_W)) i_tap (
        .ctrl (dly_ctrl),
        .eff  (eff)
    );

    actor_delay_line #(.DATA_W(DATA_W), .MAX_DELAY(MAX_DELAY), .DLY_W(DLY_W)) i_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .din    (res),
        .eff    (eff),
        .dout   (y),
        .dvalid (y_valid)
    );

    assert_const_ignores_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && fn_sel == 3'd0 && eff == '0) |=> (y == $past(coef)));

    assert_sum_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && fn_sel == 3'd2 && eff == '0) |=> (y == $past(x1 + x2)));

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (!y_valid && y == '0));
endmodule

// File: tb/test_dataflow_actor_delay.sv
module test_dataflow_actor_delay;
    localparam int CLK_PERIOD = 10;
    localparam int MAXD = 12;
    localparam int CW   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fire = 1'b0;
    logic [2:0]  fn_sel = '0;
    logic [31:0] coef = '0, x1 = '0, x2 = '0;
    logic [CW-1:0] dly_ctrl = '0;
    logic [31:0] y;
    logic        y_valid;

    int checks = 0, fails = 0;
    logic [31:0] hist [4096];
    int nf = 0;
    logic [31:0] last_y = '0;
    bit done = 0;
    logic [31:0] lfsr = 32'hACE1_2468;
    logic [31:0] vals [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dataflow_actor_delay #(.MAX_DELAY(MAXD), .CTRL_W(CW)) i_dataflow_actor_delay (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fn_sel(fn_sel), .coef(coef),
        .x1(x1), .x2(x2), .dly_ctrl(dly_ctrl), .y(y), .y_valid(y_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] msat(input logic [31:0] a, input logic [31:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        p = p >>> 16;
        if (p > 64'sd2147483647) return 32'h7FFF_FFFF;
        if (p < -64'sd2147483648) return 32'h8000_0000;
        return p[31:0];
    endfunction

    function automatic logic [31:0] ref_f(input int f, input logic [31:0] p,
                                          input logic [31:0] a, input logic [31:0] b);
        case (f)
            0: return p;
            1: return msat(p, a) + b;
            2: return a + b;
            3: return msat(a, b);
            4: return msat(p, a);
            default: return 32'h0;
        endcase
    endfunction

    // One firing driven at a falling edge, output judged at the next one.
    task automatic do_fire(input string req, input int f, input logic [31:0] p,
                           input logic [31:0] a, input logic [31:0] b, input int c);
        int e;
        logic [31:0] r, exp;
        fire = 1'b1; fn_sel = 3'(f); coef = p; x1 = a; x2 = b; dly_ctrl = CW'(c);
        e = (MAXD * c) >> CW;
        if (e > MAXD) e = MAXD;
        r = ref_f(f, p, a, b);
        if (e == 0) exp = r;
        else if (e > nf) exp = 32'h0;
        else exp = hist[nf - e];
        hist[nf] = r;
        nf++;
        @(negedge clk);
        check(req, y, exp);
        check("R8", {31'b0, y_valid}, 32'h1);
        last_y = exp;
    endtask

    // One idle cycle: no valid, output held.
    task automatic idle_cycle(input string req);
        fire = 1'b0;
        x1 = lfsr; x2 = ~lfsr; coef = lfsr ^ 32'h5A5A;
        @(negedge clk);
        check("R8", {31'b0, y_valid}, 32'h0);
        check(req, y, last_y);
    endtask

    task automatic apply_reset();
        fire = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9", y, 32'h0);
        check("R9", {31'b0, y_valid}, 32'h0);
        rst_n = 1'b1;
        nf = 0;
        last_y = 32'h0;
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        string tag;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0001_0000;
        vals[2] = 32'hFFFF_0000; vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000; vals[5] = 32'h0001_8000;
        vals[6] = 32'hFFFE_8000; vals[7] = 32'h1234_5678;

        @(negedge clk);
        apply_reset();

        // R7: long delays right after reset read as zero.
        do_fire("R7", 2, 32'h1, 32'h11, 32'h22, 255);
        do_fire("R7", 0, 32'h77, 32'h0, 32'h0, 100);

        // Phase 1: every function over all operand pairs at zero delay (R6).
        for (int f = 0; f < 8; f++) begin
            case (f)
                0: tag = "R1";
                2: tag = "R2";
                3: tag = "R3";
                default: tag = "R4";
            endcase
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    do_fire(tag, f, vals[(i + j) % 8], vals[i], vals[j], 0);
        end
        idle_cycle("R8");

        // Phase 2: full control sweep after a fresh reset, with idle gaps (R5, R7, R10).
        apply_reset();
        for (int k = 0; k < 512; k++) begin
            lfsr = step(lfsr);
            do_fire((k < 256) ? "R5" : "R7", k % 5, lfsr ^ 32'h0003_1000,
                    lfsr, {lfsr[15:0], lfsr[31:16]}, k % 256);
            if (k % 7 == 3) idle_cycle("R10");
        end

        // Phase 3: descending sweep, constant function with noisy operands (R1, R10).
        for (int c = 255; c >= 0; c -= 3) begin
            lfsr = step(lfsr);
            do_fire("R1", 0, 32'h100 + 32'(c), lfsr, ~lfsr, c);
            if (c % 2 == 0) idle_cycle("R10");
        end

        // Phase 4: mid-run reset forgets history (R9, R7).
        apply_reset();
        for (int k = 0; k < 20; k++) begin
            lfsr = step(lfsr);
            do_fire("R9", 3, 32'h0, lfsr, 32'h0002_0000, 255 - k * 3);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule